// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This block moves configuration item data between an item store and system memory without the host touching each byte. The host places a 16-byte descriptor in memory and writes that descriptor's 64-bit address into a small doorbell register. The engine then does four things in order:

- It fetches the descriptor over a byte-wide memory master port.
- It optionally switches to a new configuration item.
- It performs one read, write or skip operation against the current item.
- It writes a completion word back over the descriptor's control field.

The item store lives outside this block. The engine reaches it through a byte-lane port that carries three things: the current key, the current offset, and a write strobe. The store answers with presence, length, writability and the byte at the offset.

Reads of the doorbell region never touch the engine state. They return a slice of a fixed 64-bit identification constant, so software can probe for the engine before using it.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset, `busy` is 0 and `mem_req` is 0. `item_key` and `item_off` are both 0. `item_sel` is low.
- R2: A doorbell read of width 2^`db_size` bytes at byte offset `db_addr` returns the constant's bytes from that offset on, right-aligned in `db_rdata`. The byte at offset 0 is the most significant byte of the constant. A window that runs past byte 7 reads 0.
- R3: Doorbell writes decode as follows, where `db_size` 2 means 4 bytes and 3 means 8 bytes:
  - A 4-byte write at offset 0 stores the upper address half.
  - A 4-byte write at offset 4 supplies the lower half and starts a transfer.
  - An 8-byte write at offset 0 starts a transfer with the full address.
  - Starting clears the stored upper half.
  - Every doorbell write is ignored while `busy` is 1.
  - `busy` is 1 on the cycle after a starting write.
- R4: The descriptor is fetched byte by byte from ascending addresses as big-endian fields: a 32-bit control word at bytes 0-3, a 32-bit length at bytes 4-7, and a 64-bit memory address at bytes 8-15.
- R5: Control bit 3 (0x08) selects control bits 31:16 as the new `item_key`. It also resets `item_off` to 0 before the operation, with a one-cycle `item_sel` pulse.
- R6: The operation is chosen by control bits in this priority order: read (0x02), then write (0x10), then skip (0x04). With none of them set, the length counts as zero.
- R7: A read writes the item's bytes from the current offset to ascending memory addresses. Once the item is exhausted or absent, it writes 0x00 instead. The item offset only advances while inside the item.
- R8: A skip writes no memory. It advances the offset by the smaller of the length and the bytes left in the item.
- R9: A nonzero-length write succeeds only if the item is present, writable, and has at least `length` bytes left. On success it copies memory bytes into the item through `item_we`. On failure it sets status bit 0 (0x01) and touches nothing.
- R10: A memory fault (`mem_err` with `mem_ack`) sets the error bit and ends the operation at once. This applies during descriptor fetch or data movement.
- R11: At the end, the engine writes a 4-byte big-endian status to descriptor bytes 0-3: 0x00000000 on success and 0x00000001 on error. `busy` falls after the last status byte is accepted.
- R12: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| db_wr | input | 1 | Doorbell write strobe |
| db_addr | input | 3 | Doorbell byte offset |
| db_size | input | 2 | Access width, log2 bytes |
| db_wdata | input | 64 | Doorbell write data, right-aligned |
| db_rdata | output | 64 | Doorbell read data (identification slice) |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory request done |
| mem_err | input | 1 | Memory fault, valid with ack |
| mem_rdata | input | 8 | Memory read byte, valid with ack |
| item_key | output | 16 | Current item key |
| item_sel | output | 1 | Pulse on item selection |
| item_off | output | 32 | Current item byte offset |
| item_we | output | 1 | Item byte write strobe |
| item_wdata | output | 8 | Item write byte |
| item_present | input | 1 | Current key names an item |
| item_writable | input | 1 | Current item accepts writes |
| item_len | input | 32 | Current item length in bytes |
| item_rdata | input | 8 | Item byte at `item_off` |

## Verification
The identification read is combinational and is sampled in the same cycle its address is driven. `busy` is checked one cycle after a starting doorbell write. Every other result comes from the memory handshake, so its timing depends on when the responder acknowledges. The bench therefore does not count cycles for data. A scoreboard compares each memory write against the next queued expectation on the edge that completes it. At the end of each job it confirms the queue is empty and compares the item contents and the item-write count.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  parameter int ADDR_W = 64;
  parameter int LEN_W  = 32;
  parameter int KEY_W  = 16;
  parameter int CTL_W  = 32;
  localparam int DESC_BYTES   = (CTL_W + LEN_W + ADDR_W) / 8;
  localparam int DESC_W       = DESC_BYTES * 8;
  localparam int STATUS_BYTES = CTL_W / 8;
  localparam int CNT_W        = $clog2(DESC_BYTES);

  // control word bit positions
  localparam int B_ERR   = 0;
  localparam int B_READ  = 1;
  localparam int B_SKIP  = 2;
  localparam int B_SEL   = 3;
  localparam int B_WRITE = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_PLAN, ST_MOVE, ST_STATUS
  } dma_state_t;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_SKIP} dma_op_t;

  function automatic dma_op_t pick_op(input logic [CTL_W-1:0] c);
    if (c[B_READ])       return OP_READ;
    else if (c[B_WRITE]) return OP_WRITE;
    else if (c[B_SKIP])  return OP_SKIP;
    return OP_NONE;
  endfunction

  function automatic logic [LEN_W-1:0] item_left(input logic [LEN_W-1:0] len,
                                                 input logic [LEN_W-1:0] off,
                                                 input logic present);
    if (present && off < len) return len - off;
    return '0;
  endfunction

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic write_fits(input logic [LEN_W-1:0] rem,
                                      input logic [LEN_W-1:0] left,
                                      input logic wok);
    return wok && (rem <= left);
  endfunction
endpackage

// File: rtl/cfgdma_doorbell.sv
module cfgdma_doorbell
  import cfgdma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4d41_5331
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [1:0]        size,
  input  logic [63:0]       wdata,
  input  logic              busy,
  output logic [63:0]       rdata,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0] hi_q;
  logic wr_hi, wr_lo, wr_full;

  function automatic logic [63:0] sig_window(input logic [2:0] a, input logic [1:0] s);
    int n;
    int sh;
    logic [63:0] mask;
    n = 1 << s;
    if (int'(a) + n > 8) return '0;
    sh = 8 * (8 - int'(a) - n);
    mask = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
    return (SIGNATURE >> sh) & mask;
  endfunction

  assign wr_hi   = wr && !busy && size == 2'd2 && addr == 3'd0;
  assign wr_lo   = wr && !busy && size == 2'd2 && addr == 3'd4;
  assign wr_full = wr && !busy && size == 2'd3 && addr == 3'd0;

  assign start      = wr_lo || wr_full;
  assign start_addr = wr_full ? wdata[ADDR_W-1:0] : {hi_q, wdata[HALF_W-1:0]};
  assign rdata      = sig_window(addr, size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (start)  hi_q <= '0;
    else if (wr_hi)  hi_q <= wdata[HALF_W-1:0];
  end
endmodule

// File: rtl/cfgdma_ctl.sv
module cfgdma_ctl
  import cfgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [7:0]        mem_rdata,
  output logic [KEY_W-1:0]  item_key,
  output logic              item_sel,
  output logic [LEN_W-1:0]  item_off,
  output logic              item_we,
  output logic [7:0]        item_wdata,
  input  logic              item_present,
  input  logic              item_writable,
  input  logic [LEN_W-1:0]  item_len,
  input  logic [7:0]        item_rdata
);
  dma_state_t        st;
  dma_op_t           op;
  logic [ADDR_W-1:0] desc_addr, cur_addr;
  logic [DESC_W-1:0] desc_buf;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  rem, off, left_now;
  logic [KEY_W-1:0]  key;
  logic              sel_q, err_q, in_item, beat_ok;
  logic [CTL_W-1:0]  d_ctl;

  assign d_ctl    = desc_buf[DESC_W-1 -: CTL_W];
  assign left_now = item_left(item_len, off, item_present);
  assign in_item  = left_now != '0;
  assign beat_ok  = mem_ack && !mem_err;

  assign busy       = st != ST_IDLE;
  assign item_key   = key;
  assign item_off   = off;
  assign item_sel   = sel_q;
  assign item_we    = st == ST_MOVE && op == OP_WRITE && beat_ok;
  assign item_wdata = mem_rdata;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(cnt);
      end
      ST_MOVE: begin
        mem_req   = 1'b1;
        mem_we    = op == OP_READ;
        mem_addr  = cur_addr;
        mem_wdata = in_item ? item_rdata : 8'h00;
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + ADDR_W'(cnt);
        mem_wdata = (cnt == CNT_W'(STATUS_BYTES - 1)) ? {7'b0, err_q} : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op        <= OP_NONE;
      desc_addr <= '0;
      cur_addr  <= '0;
      desc_buf  <= '0;
      cnt       <= '0;
      rem       <= '0;
      off       <= '0;
      key       <= '0;
      sel_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      sel_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          desc_addr <= start_addr;
          cnt       <= '0;
          err_q     <= 1'b0;
          st        <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            cnt   <= '0;
            st    <= ST_STATUS;
          end else begin
            desc_buf <= {desc_buf[DESC_W-9:0], mem_rdata};
            cnt      <= cnt + 1'b1;
            if (cnt == CNT_W'(DESC_BYTES - 1)) st <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          rem      <= desc_buf[ADDR_W +: LEN_W];
          cur_addr <= desc_buf[ADDR_W-1:0];
          op       <= pick_op(d_ctl);
          if (d_ctl[B_SEL]) begin
            key   <= d_ctl[CTL_W-1 -: KEY_W];
            off   <= '0;
            sel_q <= 1'b1;
          end
          st <= ST_PLAN;
        end
        ST_PLAN: begin
          cnt <= '0;
          unique case (op)
            OP_NONE: begin
              rem <= '0;
              st  <= ST_STATUS;
            end
            OP_SKIP: begin
              off <= off + min_len(rem, left_now);
              rem <= '0;
              st  <= ST_STATUS;
            end
            OP_WRITE: begin
              if (rem == '0) st <= ST_STATUS;
              else if (!write_fits(rem, left_now, item_present && item_writable)) begin
                err_q <= 1'b1;
                st    <= ST_STATUS;
              end else st <= ST_MOVE;
            end
            default: st <= (rem == '0) ? ST_STATUS : ST_MOVE;
          endcase
        end
        ST_MOVE: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            st    <= ST_STATUS;
          end else begin
            cur_addr <= cur_addr + 1'b1;
            rem      <= rem - 1'b1;
            if (in_item) off <= off + 1'b1;
            if (rem == LEN_W'(1)) st <= ST_STATUS;
          end
        end
        ST_STATUS: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(STATUS_BYTES - 1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4d41_5331
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_wr,
  input  logic [2:0]        db_addr,
  input  logic [1:0]        db_size,
  input  logic [63:0]       db_wdata,
  output logic [63:0]       db_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [7:0]        mem_rdata,
  output logic [KEY_W-1:0]  item_key,
  output logic              item_sel,
  output logic [LEN_W-1:0]  item_off,
  output logic              item_we,
  output logic [7:0]        item_wdata,
  input  logic              item_present,
  input  logic              item_writable,
  input  logic [LEN_W-1:0]  item_len,
  input  logic [7:0]        item_rdata
);
  logic              ev_start;
  logic [ADDR_W-1:0] ev_start_addr;

  cfgdma_doorbell #(.SIGNATURE(SIGNATURE)) u_door (
    .clk(clk), .rst_n(rst_n), .wr(db_wr), .addr(db_addr), .size(db_size),
    .wdata(db_wdata), .busy(busy), .rdata(db_rdata),
    .start(ev_start), .start_addr(ev_start_addr)
  );

  cfgdma_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .start_addr(ev_start_addr),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .item_key(item_key), .item_sel(item_sel),
    .item_off(item_off), .item_we(item_we), .item_wdata(item_wdata),
    .item_present(item_present), .item_writable(item_writable),
    .item_len(item_len), .item_rdata(item_rdata)
  );
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk
  import cfgdma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              db_wr,
  input logic              ev_start,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              item_sel,
  input logic [LEN_W-1:0]  item_off,
  input logic              item_we,
  input logic              item_present,
  input logic              item_writable,
  input logic [LEN_W-1:0]  item_len
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !item_we) else $error("idle engine active"); // R1
  AST_BUSY_FROM_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(db_wr) && $past(ev_start)) else $error("busy without doorbell"); // R3
  AST_SEL_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    item_sel |-> item_off == '0) else $error("offset not reset on select"); // R5
  AST_ITEM_WRITE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    item_we |-> item_present && item_writable && item_off < item_len) else $error("bad item write"); // R9
  AST_STATUS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_ack) && $past(mem_we)) else $error("finished without write-back"); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)) else $error("request dropped"); // R12
endmodule

bind cfgdma_engine cfgdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .ev_start(ev_start), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .item_sel(item_sel), .item_off(item_off), .item_we(item_we),
  .item_present(item_present), .item_writable(item_writable), .item_len(item_len)
);

// File: tb/cfgdma_engine_bench.sv
`timescale 1ns/1ps
module cfgdma_engine_bench;
  localparam logic [63:0] SIG = 64'h4346_4744_4d41_5331;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic db_wr = 0;
  logic [2:0] db_addr = 0;
  logic [1:0] db_size = 0;
  logic [63:0] db_wdata = 0;
  logic [63:0] db_rdata;
  logic busy, mem_req, mem_we, item_sel, item_we;
  logic [63:0] mem_addr;
  logic [7:0] mem_wdata, item_wdata;
  logic [15:0] item_key;
  logic [31:0] item_off;
  logic ack_r = 0, err_r = 0;
  logic [7:0] rd_r = 0;
  logic present, wok;
  logic [31:0] ilen;
  logic [7:0] irdata;

  cfgdma_engine #(.SIGNATURE(SIG)) u_cfgdma_engine (
    .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_addr(db_addr), .db_size(db_size),
    .db_wdata(db_wdata), .db_rdata(db_rdata), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(ack_r),
    .mem_err(err_r), .mem_rdata(rd_r), .item_key(item_key), .item_sel(item_sel),
    .item_off(item_off), .item_we(item_we), .item_wdata(item_wdata),
    .item_present(present), .item_writable(wok), .item_len(ilen), .item_rdata(irdata)
  );

  int checks = 0, errors = 0, we_cnt = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] wbuf [0:3];

  typedef struct { logic [63:0] a; logic [7:0] d; string req; } wr_t;
  wr_t expq[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // item store model: key0 len4 ro, key1 len6 ro, key2 len8 ro, key3 len4 writable
  always_comb begin
    present = 1'b1; wok = 1'b0; ilen = 0; irdata = 8'hEE;
    case (item_key)
      16'd0: begin ilen = 4; if (item_off < 4) irdata = 8'hA0 + item_off[7:0]; end
      16'd1: begin ilen = 6; if (item_off < 6) irdata = 8'h10 + item_off[7:0]; end
      16'd2: begin ilen = 8; if (item_off < 8) irdata = 8'h20 + item_off[7:0]; end
      16'd3: begin ilen = 4; wok = 1'b1; if (item_off < 4) irdata = wbuf[item_off[1:0]]; end
      default: present = 1'b0;
    endcase
  end

  always @(posedge clk) if (rst_n && item_we) begin
    wbuf[item_off[1:0]] <= item_wdata;
    we_cnt <= we_cnt + 1;
  end

  // memory responder and scoreboard monitor: faults at 1024 and above
  always @(posedge clk) begin
    if (!rst_n) ack_r <= 1'b0;
    else if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      err_r <= mem_addr >= 64'd1024;
      rd_r  <= (mem_addr < 64'd1024) ? mem[mem_addr[9:0]] : 8'h00;
    end else begin
      ack_r <= 1'b0;
      if (ack_r && mem_req && mem_we) begin
        if (!err_r) mem[mem_addr[9:0]] <= mem_wdata;
        if (expq.size() == 0) check(0, "R7 unexpected write", mem_addr, 0);
        else begin
          wr_t e;
          e = expq.pop_front();
          check(mem_addr == e.a && mem_wdata == e.d, e.req,
                {mem_addr[55:0], mem_wdata}, {e.a[55:0], e.d});
        end
      end
    end
  end

  task automatic push(input logic [63:0] a, input logic [7:0] d, input string req);
    expq.push_back('{a: a, d: d, req: req});
  endtask

  task automatic push_status(input logic [63:0] base, input bit e);
    for (int i = 0; i < 4; i++) push(base + i, (i == 3) ? {7'b0, e} : 8'h00, "R11 status");
  endtask

  task automatic put_desc(input int base, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [63:0] addr);
    for (int i = 0; i < 4; i++) mem[base + i] = ctl[31 - 8*i -: 8];
    for (int i = 0; i < 4; i++) mem[base + 4 + i] = len[31 - 8*i -: 8];
    for (int i = 0; i < 8; i++) mem[base + 8 + i] = addr[63 - 8*i -: 8];
  endtask

  task automatic db_write(input logic [2:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    db_wr = 1; db_addr = a; db_size = s; db_wdata = d;
    @(negedge clk);
    db_wr = 0;
  endtask

  task automatic wait_idle(input string req);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic job(input int base, input string req);
    db_write(3'd0, 2'd3, 64'(base));
    check(busy == 1'b1, "R3 busy after start", busy, 1);
    wait_idle(req);
  endtask

  function automatic logic [63:0] sig_exp(input int a, input int n);
    logic [63:0] v = 0;
    if (a + n > 8) return 0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(SIG[63 - 8*(a+i) -: 8]);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !mem_req && item_key == 0 && item_off == 0 && !item_sel, "R1 reset",
          {busy, mem_req, item_sel, item_key, item_off}, 0);

    // R2 identification reads
    db_addr = 0; db_size = 3; #1 check(db_rdata == sig_exp(0, 8), "R2 sig 8@0", db_rdata, sig_exp(0, 8));
    db_addr = 7; db_size = 0; #1 check(db_rdata == sig_exp(7, 1), "R2 sig 1@7", db_rdata, sig_exp(7, 1));
    db_addr = 2; db_size = 1; #1 check(db_rdata == sig_exp(2, 2), "R2 sig 2@2", db_rdata, sig_exp(2, 2));
    db_addr = 4; db_size = 2; #1 check(db_rdata == sig_exp(4, 4), "R2 sig 4@4", db_rdata, sig_exp(4, 4));
    db_addr = 6; db_size = 2; #1 check(db_rdata == 0, "R2 sig overrun", db_rdata, 0);

    // R4 R5 R7: select key1, read 4
    put_desc(32'h000, (32'd1 << 16) | 32'h0A, 4, 64'h200);
    for (int i = 0; i < 4; i++) push(64'h200 + i, 8'h10 + 8'(i), "R7 read");
    push_status(64'h000, 0);
    job(32'h000, "R4 read job");
    // R7 continue without select: two item bytes then zero fill
    put_desc(32'h020, 32'h02, 4, 64'h210);
    push(64'h210, 8'h14, "R7 read"); push(64'h211, 8'h15, "R7 read");
    push(64'h212, 8'h00, "R7 zero fill"); push(64'h213, 8'h00, "R7 zero fill");
    push_status(64'h020, 0);
    job(32'h020, "R7 tail job");

    // R8 skip then read
    put_desc(32'h040, (32'd2 << 16) | 32'h0C, 3, 64'h0);
    push_status(64'h040, 0);
    job(32'h040, "R8 skip");
    put_desc(32'h060, 32'h02, 2, 64'h220);
    push(64'h220, 8'h23, "R8 offset after skip"); push(64'h221, 8'h24, "R8 offset after skip");
    push_status(64'h060, 0);
    job(32'h060, "R8 read after skip");
    put_desc(32'h080, 32'h04, 10, 64'h0);
    push_status(64'h080, 0);
    job(32'h080, "R8 long skip");
    put_desc(32'h0A0, 32'h02, 1, 64'h228);
    push(64'h228, 8'h00, "R8 skip clamps to item end");
    push_status(64'h0A0, 0);
    job(32'h0A0, "R8 clamp");

    // R9 write success
    mem[12'h300] = 8'h5A; mem[12'h301] = 8'hA5; mem[12'h302] = 8'h3C; mem[12'h303] = 8'hC3;
    put_desc(32'h0E0, (32'd3 << 16) | 32'h18, 4, 64'h300);
    push_status(64'h0E0, 0);
    job(32'h0E0, "R9 write job");
    check({wbuf[0], wbuf[1], wbuf[2], wbuf[3]} == 32'h5AA53CC3, "R9 item written",
          {wbuf[0], wbuf[1], wbuf[2], wbuf[3]}, 32'h5AA53CC3);
    // R6 read beats write
    put_desc(32'h100, (32'd3 << 16) | 32'h1A, 4, 64'h230);
    push(64'h230, 8'h5A, "R6 read priority"); push(64'h231, 8'hA5, "R6 read priority");
    push(64'h232, 8'h3C, "R6 read priority"); push(64'h233, 8'hC3, "R6 read priority");
    push_status(64'h100, 0);
    job(32'h100, "R6 priority job");
    // R9 write too long
    for (int i = 0; i < 5; i++) mem[12'h310 + i] = 8'h11 * 8'(i + 1);
    put_desc(32'h120, (32'd3 << 16) | 32'h18, 5, 64'h310);
    push_status(64'h120, 1);
    job(32'h120, "R9 too long");
    check({wbuf[0], wbuf[1], wbuf[2], wbuf[3]} == 32'h5AA53CC3, "R9 item unchanged",
          {wbuf[0], wbuf[1], wbuf[2], wbuf[3]}, 32'h5AA53CC3);
    // R9 write read-only item
    put_desc(32'h140, (32'd1 << 16) | 32'h18, 2, 64'h310);
    push_status(64'h140, 1);
    job(32'h140, "R9 read-only");
    check(we_cnt == 4, "R9 no item writes on error", we_cnt, 4);

    // R6 no operation bits; R5 offset reset visible afterwards
    put_desc(32'h160, (32'd2 << 16) | 32'h08, 5, 64'h240);
    push_status(64'h160, 0);
    job(32'h160, "R6 no op");
    check(item_key == 16'd2 && item_off == 0, "R5 select key/offset", {item_key, item_off}, {16'd2, 32'd0});
    put_desc(32'h180, 32'h02, 1, 64'h238);
    push(64'h238, 8'h20, "R5 offset reset");
    push_status(64'h180, 0);
    job(32'h180, "R5 read");

    // R7 absent item zero fill
    put_desc(32'h1A0, (32'd9 << 16) | 32'h0A, 3, 64'h240);
    for (int i = 0; i < 3; i++) push(64'h240 + i, 8'h00, "R7 absent zero fill");
    push_status(64'h1A0, 0);
    job(32'h1A0, "R7 absent");

    // R10 fault during data movement
    put_desc(32'h1C0, (32'd1 << 16) | 32'h0A, 3, 64'd1022);
    push(64'd1022, 8'h10, "R10 before fault"); push(64'd1023, 8'h11, "R10 before fault");
    push(64'd1024, 8'h12, "R10 faulting write");
    push_status(64'h1C0, 1);
    job(32'h1C0, "R10 data fault");
    // R10 fault during descriptor fetch
    push_status(64'h7D0, 1);
    job(32'h7D0, "R10 fetch fault");

    // R3 split doorbell loads upper half
    db_write(3'd0, 2'd2, 64'h1);
    push_status(64'h1_0000_00E0, 1);
    db_write(3'd4, 2'd2, 64'hE0);
    check(busy == 1'b1, "R3 split start", busy, 1);
    wait_idle("R3 split address");
    // R3 upper half write while busy ignored; cleared by previous start
    put_desc(32'h1E0, (32'd2 << 16) | 32'h0A, 8, 64'h250);
    for (int i = 0; i < 8; i++) push(64'h250 + i, 8'h20 + 8'(i), "R7 long read");
    push_status(64'h1E0, 0);
    db_write(3'd0, 2'd3, 64'h1E0);
    db_write(3'd0, 2'd2, 64'h1);
    wait_idle("R3 busy job");
    put_desc(32'h0C0, 32'h0A, 4, 64'h280);
    for (int i = 0; i < 4; i++) push(64'h280 + i, 8'hA0 + 8'(i), "R3 ignored upper half");
    push_status(64'h0C0, 0);
    db_write(3'd4, 2'd2, 64'hC0);
    wait_idle("R3 low-only start");
    check(mem[12'h0C3] == 8'h00, "R11 status byte in memory", mem[12'h0C3], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule